// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block turns changes on a wide bank of general-purpose input pins into one interrupt request. The pins are split into groups of eight. Software gives every pin a trigger kind: a low or high level, a falling or rising edge, or any edge. The block registers the pin inputs and compares each sample with the previous one. It records every qualifying event in a per-group pending register and gates the pending bits with a per-group mask register. It then drives a single registered interrupt line, which stays high while any unmasked pending bit is set.

Software reaches three register arrays through a 32-bit register bus with a single-cycle write strobe and a combinational read path. The three arrays hold the trigger kinds, the masks and the pending bits. An interrupt service routine reads each group's pending word, ignores the masked bits and services the rest. It then clears the bits it handled by writing ones to them.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Reset is synchronous and active low. During reset every trigger field becomes 0, every mask bit becomes 1, every pending bit becomes 0, and `irq_o` becomes 0.
- R2: The register map is as follows, with group g running from 0 to 20. Trigger words are at 0x700+4g, mask words at 0x900+4g and pending words at 0xA00+4g. Pin p of a group has its trigger field at bits 4p+3..4p of the trigger word, and its mask and pending bits at bit p. Bits 31..8 of mask and pending words read as 0. An address outside these arrays, or one that is not word aligned, reads as 0 and a write to it changes nothing.
- R3: Trigger code 0 (low level) sets the pin's pending bit on every cycle in which the sampled pin is 0. Trigger code 1 (high level) does the same on every cycle in which the sampled pin is 1.
- R4: Edge triggers compare the current sample with the previous sample. Code 2 sets the pending bit on a 1-to-0 change, code 3 on a 0-to-1 change, and code 4 on either change. A steady pin sets nothing.
- R5: Trigger codes 5 to 15 never set a pending bit.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. When an event and a clear of the same bit occur in the same cycle, the bit stays set. A pending bit is cleared only by such a write or by reset.
- R7: A pin change driven before rising edge k is captured at edge k. Its pending bit is set at edge k+1, and `irq_o` rises at edge k+2 if the pin is unmasked. `irq_o` is the registered OR, across all groups, of the pending bits whose mask bit is 0.
- R8: No pending bit is set at the first two clock edges after reset is released, whatever the pins and trigger fields are.
- R9: A mask bit of 1 blocks only the interrupt output. The pending bit of a masked pin is still set and still reads back as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 168 | Pin inputs, pin p of group g at bit 8g+p |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `pins_i` is already synchronous to `clk`. They also assume that reset is a clean low pulse, and that a bus write takes effect at the single edge where `reg_en` and `reg_we` are both high. The bench changes pins and bus signals only on falling clock edges and raises `reg_en` for exactly one rising edge per access. It holds reset for several cycles at the start. Before each change of a trigger field, the bench parks the target pin at a known level, so the only event it expects is the one set up by the pin change that follows.

// File: rtl/gic_pkg.sv
// Shared constants and event rule for the GPIO interrupt controller.
// Assumes eight pins per group and a four-bit trigger field per pin.
package gic_pkg;
    localparam int PINS_PER_GROUP = 8;
    localparam int FIELD_W        = 4;
    localparam int CTRL_W         = PINS_PER_GROUP * FIELD_W;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_LEVEL_LO = 4'd0,
        TRIG_LEVEL_HI = 4'd1,
        TRIG_FALL     = 4'd2,
        TRIG_RISE     = 4'd3,
        TRIG_ANY_EDGE = 4'd4
    } trig_e;

    // Event rule for one pin, from its trigger code and two successive samples.
    function automatic logic pin_event(input logic [FIELD_W-1:0] kind,
                                       input logic now_s, input logic old_s);
        logic hit;
        case (kind)
            TRIG_LEVEL_LO: hit = ~now_s;
            TRIG_LEVEL_HI: hit = now_s;
            TRIG_FALL:     hit = old_s & ~now_s;
            TRIG_RISE:     hit = ~old_s & now_s;
            TRIG_ANY_EDGE: hit = old_s ^ now_s;
            default:       hit = 1'b0;
        endcase
        return hit;
    endfunction
endpackage

// File: rtl/gic_addr_decode.sv
// Address decoder for the three per-group register arrays (trigger, mask, pending).
// Assumes word-strided groups. An unaligned or out-of-range address hits nothing.
module gic_addr_decode #(
    parameter int ADDR_W     = 12,
    parameter int NUM_GROUPS = 21,
    parameter int CTRL_BASE  = 'h700,
    parameter int MASK_BASE  = 'h900,
    parameter int PEND_BASE  = 'hA00
) (
    input  logic [ADDR_W-1:0]                       addr,
    output logic [2:0]                              hit,
    output logic [2:0][$clog2(NUM_GROUPS)-1:0]      idx
);
    localparam int GIDX_W = $clog2(NUM_GROUPS);

    for (genvar r = 0; r < 3; r++) begin : g_region
        localparam int BASE = (r == 0) ? CTRL_BASE : (r == 1) ? MASK_BASE : PEND_BASE;
        logic [ADDR_W-1:0] off;
        // Offset from the region base, then range and alignment test.
        assign off    = addr - ADDR_W'(BASE);
        assign hit[r] = (addr >= ADDR_W'(BASE)) && (off[1:0] == 2'b00) &&
                        (off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_GROUPS));
        assign idx[r] = off[GIDX_W+1:2];
    end
endmodule

// File: rtl/gic_pin_sampler.sv
// Registers the pin bank twice to get a current and a previous sample.
// Assumes pins are already synchronous. armed_o goes high once both stages hold real data.
module gic_pin_sampler #(
    parameter int WIDTH = 168
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o,
    output logic             armed_o
);
    logic [1:0] fill;

    // Two-stage sample shift plus the fill tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o  <= '0;
            prev_o <= '0;
            fill   <= '0;
        end else begin
            cur_o  <= pins_i;
            prev_o <= cur_o;
            fill   <= {fill[0], 1'b1};
        end
    end

    assign armed_o = fill[1];
endmodule

// File: rtl/gic_group_slice.sv
// State for one group of pins: trigger word, mask byte and pending byte.
// Assumes the write strobes are already decoded for this group. Events beat clears.
module gic_group_slice
    import gic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PINS_PER_GROUP-1:0] cur_i,
    input  logic [PINS_PER_GROUP-1:0] prev_i,
    input  logic                      armed_i,
    input  logic                      wr_ctrl,
    input  logic                      wr_mask,
    input  logic                      wr_pend,
    input  logic [CTRL_W-1:0]         wdata,
    output logic [CTRL_W-1:0]         ctrl_o,
    output logic [PINS_PER_GROUP-1:0] mask_o,
    output logic [PINS_PER_GROUP-1:0] pend_o
);
    logic [PINS_PER_GROUP-1:0] ev;
    logic [PINS_PER_GROUP-1:0] clr;

    for (genvar p = 0; p < PINS_PER_GROUP; p++) begin : g_pin
        // Per-pin event from its own trigger field.
        assign ev[p] = armed_i & pin_event(ctrl_o[p*FIELD_W +: FIELD_W], cur_i[p], prev_i[p]);
    end

    assign clr = wr_pend ? wdata[PINS_PER_GROUP-1:0] : '0;

    // Trigger word: plain write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_o <= '0;
        else if (wr_ctrl) ctrl_o <= wdata;
    end

    // Mask byte: plain write, resets to all masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '1;
        else if (wr_mask) mask_o <= wdata[PINS_PER_GROUP-1:0];
    end

    // Pending byte: write-one-to-clear with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr) | ev;
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO interrupt controller: sampler, decoder, group slices, read mux, interrupt register.
// Assumes one register access per cycle and reads without side effects.
module gpio_irq_ctrl
    import gic_pkg::*;
#(
    parameter int NUM_GROUPS = 21,
    parameter int ADDR_W     = 12,
    parameter int CTRL_BASE  = 'h700,
    parameter int MASK_BASE  = 'h900,
    parameter int PEND_BASE  = 'hA00
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_GROUPS*PINS_PER_GROUP-1:0] pins_i,
    input  logic                                 reg_en,
    input  logic                                 reg_we,
    input  logic [ADDR_W-1:0]                    reg_addr,
    input  logic [31:0]                          reg_wdata,
    output logic [31:0]                          reg_rdata,
    output logic                                 irq_o
);
    localparam int NPINS  = NUM_GROUPS * PINS_PER_GROUP;
    localparam int GIDX_W = $clog2(NUM_GROUPS);

    logic [NPINS-1:0]             cur_s, prev_s;
    logic                         armed;
    logic [2:0]                   hit;
    logic [2:0][GIDX_W-1:0]       idx;
    logic                         bus_wr;
    logic [NUM_GROUPS*CTRL_W-1:0] ctrl_all;
    logic [NPINS-1:0]             mask_all;
    logic [NPINS-1:0]             pend_all;

    gic_pin_sampler #(.WIDTH(NPINS)) u_sampler (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i),
        .cur_o(cur_s), .prev_o(prev_s), .armed_o(armed)
    );

    gic_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
        .CTRL_BASE(CTRL_BASE), .MASK_BASE(MASK_BASE), .PEND_BASE(PEND_BASE)
    ) u_decode (
        .addr(reg_addr), .hit(hit), .idx(idx)
    );

    assign bus_wr = reg_en & reg_we;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        logic wc, wm, wp;
        assign wc = bus_wr & hit[0] & (idx[0] == GIDX_W'(g));
        assign wm = bus_wr & hit[1] & (idx[1] == GIDX_W'(g));
        assign wp = bus_wr & hit[2] & (idx[2] == GIDX_W'(g));

        gic_group_slice u_slice (
            .clk(clk), .rst_n(rst_n),
            .cur_i(cur_s[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .prev_i(prev_s[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .armed_i(armed),
            .wr_ctrl(wc), .wr_mask(wm), .wr_pend(wp),
            .wdata(reg_wdata),
            .ctrl_o(ctrl_all[g*CTRL_W +: CTRL_W]),
            .mask_o(mask_all[g*PINS_PER_GROUP +: PINS_PER_GROUP]),
            .pend_o(pend_all[g*PINS_PER_GROUP +: PINS_PER_GROUP])
        );
    end

    // Read mux: selects the addressed word, zero for unmapped addresses.
    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (hit[0] && idx[0] == GIDX_W'(g)) reg_rdata = ctrl_all[g*CTRL_W +: CTRL_W];
            if (hit[1] && idx[1] == GIDX_W'(g)) reg_rdata = 32'(mask_all[g*PINS_PER_GROUP +: PINS_PER_GROUP]);
            if (hit[2] && idx[2] == GIDX_W'(g)) reg_rdata = 32'(pend_all[g*PINS_PER_GROUP +: PINS_PER_GROUP]);
        end
    end

    // Combined interrupt: registered OR of unmasked pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(pend_all & ~mask_all);
    end
endmodule

// File: rtl/gic_checker.sv
// Checker for the GPIO interrupt controller, bound to the top module.
// Assumes the bus and pins are synchronous to clk.
module gic_checker #(
    parameter int NUM_GROUPS = 21,
    parameter int ADDR_W     = 12,
    parameter int CTRL_BASE  = 'h700,
    parameter int MASK_BASE  = 'h900,
    parameter int PEND_BASE  = 'hA00
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_en,
    input logic                      reg_we,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic                      irq_o,
    input logic [NUM_GROUPS*32-1:0]  ctrl_all,
    input logic [NUM_GROUPS*8-1:0]   mask_all,
    input logic [NUM_GROUPS*8-1:0]   pend_all
);
    function automatic logic in_array(input logic [ADDR_W-1:0] a, input int base);
        int ai;
        ai = int'(a);
        return (ai >= base) && (ai < base + 4*NUM_GROUPS) && (a[1:0] == 2'b00);
    endfunction

    logic ctrl_wr, mask_wr, pend_wr;
    assign ctrl_wr = reg_en && reg_we && in_array(reg_addr, CTRL_BASE);
    assign mask_wr = reg_en && reg_we && in_array(reg_addr, MASK_BASE);
    assign pend_wr = reg_en && reg_we && in_array(reg_addr, PEND_BASE);

    p_reset_values_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_all == '0 && mask_all == '1 && ctrl_all == '0 && !irq_o));

    p_ctrl_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(ctrl_all)) |-> $past(ctrl_wr));

    p_mask_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(mask_all)) |-> $past(mask_wr));

    p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(pend_all) & ~pend_all) != '0)) |-> $past(pend_wr));

    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == |($past(pend_all) & ~$past(mask_all))));

    p_startup_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (pend_all == '0) ##1 (pend_all == '0));
endmodule

bind gpio_irq_ctrl gic_checker #(
    .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W),
    .CTRL_BASE(CTRL_BASE), .MASK_BASE(MASK_BASE), .PEND_BASE(PEND_BASE)
) i_gic_checker (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .irq_o(irq_o), .ctrl_all(ctrl_all), .mask_all(mask_all), .pend_all(pend_all)
);

// File: tb/test_gpio_irq_ctrl.sv
// Bench for gpio_irq_ctrl: a trigger-vector table walked by one loop, then directed tests.
module test_gpio_irq_ctrl;
    localparam int NG = 21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NG*8-1:0] pins;
    logic          reg_en, reg_we;
    logic [11:0]   reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [11:0] a_ctrl(input int g); return 12'(12'h700 + 4*g); endfunction
    function automatic logic [11:0] a_mask(input int g); return 12'(12'h900 + 4*g); endfunction
    function automatic logic [11:0] a_pend(input int g); return 12'(12'hA00 + 4*g); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {group[4:0], pin[2:0], trigger[3:0], start level, end level, expected pending}
    localparam logic [14:0] VEC [13] = '{
        {5'd0,  3'd0, 4'd3,  1'b0, 1'b1, 1'b1},
        {5'd0,  3'd1, 4'd3,  1'b1, 1'b0, 1'b0},
        {5'd3,  3'd2, 4'd2,  1'b1, 1'b0, 1'b1},
        {5'd3,  3'd3, 4'd2,  1'b0, 1'b1, 1'b0},
        {5'd7,  3'd4, 4'd4,  1'b0, 1'b1, 1'b1},
        {5'd7,  3'd5, 4'd4,  1'b1, 1'b0, 1'b1},
        {5'd20, 3'd4, 4'd4,  1'b1, 1'b1, 1'b0},
        {5'd10, 3'd6, 4'd1,  1'b0, 1'b0, 1'b0},
        {5'd10, 3'd7, 4'd1,  1'b0, 1'b1, 1'b1},
        {5'd20, 3'd0, 4'd0,  1'b1, 1'b1, 1'b0},
        {5'd20, 3'd7, 4'd0,  1'b1, 1'b0, 1'b1},
        {5'd15, 3'd3, 4'd5,  1'b0, 1'b1, 1'b0},
        {5'd5,  3'd2, 4'd15, 1'b1, 1'b0, 1'b0}
    };

    bit finished = 1'b0;

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; pins = '0;
        reg_en = 1'b0; reg_we = 1'b0; reg_addr = a_pend(0); reg_wdata = '0;
        repeat (4) @(negedge clk);

        // Startup: pins low, trigger code 0, no events for two edges (R8).
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 pend after reset", reg_rdata, 32'h0);
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        @(posedge clk); #2;
        chk("R8 second edge quiet", reg_rdata, 32'h0);
        @(posedge clk); #2;
        chk("R8 low level after fill", reg_rdata, 32'hFF);
        chk("R9 masked pending no irq", 32'(irq_o), 32'h0);
        rd(a_mask(20), d); chk("R1 mask reset", d, 32'hFF);
        rd(a_ctrl(9), d);  chk("R1 ctrl reset", d, 32'h0);

        pins = '1;
        idle(4);
        for (int g = 0; g < NG; g++) wr(a_pend(g), 32'hFF);
        rd(a_pend(0), d);  chk("R6 cleared", d, 32'h0);
        rd(a_pend(20), d); chk("R6 cleared last", d, 32'h0);

        // Table walk over trigger kinds.
        for (int v = 0; v < 13; v++) begin
            int g, p, t;
            logic ini, fin, ex;
            string req;
            g = int'(VEC[v][14:10]); p = int'(VEC[v][9:7]); t = int'(VEC[v][6:3]);
            ini = VEC[v][2]; fin = VEC[v][1]; ex = VEC[v][0];
            req = (t <= 1) ? "R3" : (t <= 4) ? "R4" : "R5";
            @(negedge clk); pins[g*8+p] = ini;
            idle(4);
            wr(a_ctrl(g), 32'(t) << (4*p));
            wr(a_pend(g), 32'hFF);
            wr(a_mask(g), 32'(~(8'h01 << p)));
            idle(2);
            @(negedge clk); pins[g*8+p] = fin;
            idle(4);
            rd(a_pend(g), d);
            chk(req, 32'(d[p]), 32'(ex));
            chk("R7 irq follows vector", 32'(irq_o), 32'(ex));
            wr(a_mask(g), 32'hFF);
            @(negedge clk); pins[g*8+p] = 1'b1;
            idle(4);
            wr(a_ctrl(g), 32'h0);
            wr(a_pend(g), 32'hFF);
            idle(3);
        end

        // R6: write 0 keeps, write 1 clears an edge-set bit.
        @(negedge clk); pins[2*8+0] = 1'b0;
        idle(4);
        wr(a_ctrl(2), 32'h3);
        wr(a_pend(2), 32'hFF);
        @(negedge clk); pins[2*8+0] = 1'b1;
        idle(4);
        wr(a_pend(2), 32'h00);
        rd(a_pend(2), d); chk("R6 write zero keeps", d, 32'h01);
        wr(a_pend(2), 32'h01);
        rd(a_pend(2), d); chk("R6 write one clears", d, 32'h00);

        // R6: a held level beats the clear.
        wr(a_ctrl(2), 32'h10);
        idle(3);
        wr(a_pend(2), 32'hFF);
        rd(a_pend(2), d); chk("R6 set wins over clear", d, 32'h02);
        wr(a_ctrl(2), 32'h0);
        wr(a_pend(2), 32'hFF);
        rd(a_pend(2), d); chk("R6 clear after disable", d, 32'h00);

        // R9 and R7: masked pending, then unmask and mask again.
        @(negedge clk); pins[4*8+5] = 1'b0;
        idle(4);
        wr(a_ctrl(4), 32'h3 << 20);
        wr(a_pend(4), 32'hFF);
        @(negedge clk); pins[4*8+5] = 1'b1;
        idle(4);
        rd(a_pend(4), d); chk("R9 pending while masked", d, 32'h20);
        chk("R7 masked no irq", 32'(irq_o), 32'h0);
        wr(a_mask(4), 32'hDF);
        idle(2);
        chk("R7 unmasked irq", 32'(irq_o), 32'h1);
        wr(a_mask(4), 32'hFF);
        idle(2);
        chk("R7 remasked irq low", 32'(irq_o), 32'h0);
        wr(a_pend(4), 32'hFF);
        wr(a_ctrl(4), 32'h0);

        // R7: latency from pin change to pending and interrupt.
        @(negedge clk); pins[6*8+3] = 1'b0;
        idle(4);
        wr(a_ctrl(6), 32'h3 << 12);
        wr(a_pend(6), 32'hFF);
        wr(a_mask(6), 32'hF7);
        idle(2);
        @(negedge clk); reg_addr = a_pend(6); pins[6*8+3] = 1'b1;
        @(posedge clk); #2;
        chk("R7 pending not yet", reg_rdata, 32'h00);
        @(posedge clk); #2;
        chk("R7 pending after two edges", reg_rdata, 32'h08);
        chk("R7 irq not yet", 32'(irq_o), 32'h0);
        @(posedge clk); #2;
        chk("R7 irq after three edges", 32'(irq_o), 32'h1);
        wr(a_mask(6), 32'hFF);
        wr(a_pend(6), 32'hFF);
        wr(a_ctrl(6), 32'h0);

        // R2: field readback, unmapped and unaligned addresses.
        wr(a_ctrl(1), 32'hDEADBEEF);
        rd(a_ctrl(1), d); chk("R2 ctrl readback", d, 32'hDEADBEEF);
        wr(a_ctrl(1), 32'h0);
        wr(12'h800, 32'h12345678);
        rd(12'h800, d); chk("R2 unmapped reads zero", d, 32'h0);
        wr(12'h701, 32'hFFFFFFFF);
        rd(12'h701, d); chk("R2 unaligned reads zero", d, 32'h0);
        rd(a_ctrl(0), d); chk("R2 unaligned write ignored", d, 32'h0);
        rd(a_ctrl(NG), d); chk("R2 past last group zero", d, 32'h0);
        wr(a_mask(1), 32'hFFFFFF5A);
        rd(a_mask(1), d); chk("R2 mask upper bits zero", d, 32'h5A);
        wr(a_mask(1), 32'hFF);
        rd(a_mask(0), d); chk("R2 neighbour mask kept", d, 32'hFF);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule